// File: doc/BRIEF.md
# Per-Pin Byte-Mapped GPIO Access Port

This block sits between a simple memory-mapped bus and the pin logic of a GPIO unit of up to eight 32-pin ports. Each pin gets a byte address of its own, equal to its global pin index: pin m of port n has byte address n*32+m. Port 0 therefore covers byte addresses 0 to 31, port 1 covers 32 to 63, and so on up to port 7. Software can change one pin with a byte store, two neighbouring pins with a halfword store and four pins with a word store. No read-modify-write is needed, because pins that share a bus word never share a byte.

The bus carries a word address and four byte strobes. Byte lane k of the word at word address w belongs to the pin at byte address w*4+k, and lane k occupies data bits [8k+7:8k]. A write loads bit 0 of each strobed lane into that pin's output register. A read returns, one cycle later, 0x01 or 0x00 in each lane, according to the pin's sensed level gated by its input enable. A packed parameter gives the number of pins each port implements. Byte addresses above that count are reserved.

Top module: `gpio_byte_access`

## Requirements
- R1: During and after reset, with no write yet, every bit of `pin_out` is 0 and `bus_rdata` is 0.
- R2: A write with strobe k set at word address w updates the output register of pin w*4+k, which is pin (w*4+k) mod 32 of port (w*4+k)/32. The new value is visible on `pin_out` after the clock edge that samples the write.
- R3: Only bit 8k of a strobed lane k is stored. Bits 8k+1 to 8k+7 have no effect on the pin's output.
- R4: A write with two or four strobes set updates that many adjacent pins in the same cycle. Pins in lanes whose strobe is clear keep their values.
- R5: A read at word address w loads `bus_rdata` at the next clock edge. Lane k holds 0x01 if pin w*4+k is implemented, its input enable is 1 and its `pin_in` level is 1. Otherwise lane k holds 0x00. Bits 1 to 7 of every lane are always 0.
- R6: A pin whose input enable is 0 reads as 0x00, whatever its `pin_in` level.
- R7: A pin whose index within its port is not less than that port's pin count is reserved. Its `pin_out` bit stays 0 through any write, and it reads as 0x00.
- R8: In a cycle with no write access, including a read cycle, `pin_out` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 6 | Word address; byte address of lane k is bus_waddr*4+k |
| bus_be | input | 4 | Byte strobes, bit k enables lane k |
| bus_wdata | input | 32 | Write data, lane k in bits [8k+7:8k] |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 256 | Synchronised pin levels, bit p is pin p |
| pin_ie | input | 256 | Per-pin input buffer enable |
| pin_out | output | 256 | Per-pin output registers |

## Verification
The assertions assume that `bus_waddr`, `bus_be` and `bus_wdata` are only meaningful while `bus_sel` is high. They also assume that `pin_in` and `pin_ie` are already synchronous and hold steady across the edge that captures a read. The bench drives every bus signal and pin level at the falling edge, returns the select to idle shortly after the rising edge that samples an access, and changes pin levels only between accesses. It computes the pin map and the reserved ranges from the same per-port counts it passes to the design.

// File: rtl/gpio_ba_pkg.sv
// Package gpio_ba_pkg
// Shared constants for the byte-mapped GPIO access port.
// Assumes a 32-bit bus word, which holds four byte lanes.
package gpio_ba_pkg;
    localparam int unsigned LANES   = 4;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned BUS_W   = LANES * LANE_W;
    localparam int unsigned LANE_AW = $clog2(LANES);
endpackage

// File: rtl/gpio_ba_decode.sv
// Module gpio_ba_decode
// Builds the implemented-pin mask from the per-port pin counts.
// Assumes each count field is CNT_W bits wide, with port 0 in the least
// significant field, and that a count never exceeds PORT_W.
module gpio_ba_decode #(
    parameter int unsigned NUM_PORTS = 8,
    parameter int unsigned PORT_W    = 32,
    parameter int unsigned CNT_W     = 6,
    parameter logic [NUM_PORTS*CNT_W-1:0] PORT_PINS = '1,
    localparam int unsigned NPINS = NUM_PORTS * PORT_W
) (
    output logic [NPINS-1:0] pin_impl
);
    // One constant mask bit per pin: set when the pin lies below its port's count.
    for (genvar p = 0; p < NPINS; p++) begin : g_impl
        localparam int unsigned PORT_IDX = p / PORT_W;
        localparam int unsigned PIN_IDX  = p % PORT_W;
        localparam int unsigned COUNT    = int'(PORT_PINS[PORT_IDX*CNT_W +: CNT_W]);
        assign pin_impl[p] = (PIN_IDX < COUNT);
    end
endmodule

// File: rtl/gpio_ba_outreg.sv
// Module gpio_ba_outreg
// Holds one output register per pin. A write loads bit 0 of the pin's
// byte lane when the word address matches, the lane strobe is set and the
// pin is implemented. Assumes wr_en is already qualified by the select.
module gpio_ba_outreg
    import gpio_ba_pkg::*;
#(
    parameter int unsigned NPINS   = 256,
    parameter int unsigned WADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [LANES-1:0]   be,
    input  logic [BUS_W-1:0]   wdata,
    input  logic [NPINS-1:0]   pin_impl,
    output logic [NPINS-1:0]   pin_out
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int unsigned WORD = p / LANES;
        localparam int unsigned LANE = p % LANES;
        logic hit;
        // Write hit for this pin: matching word, strobed lane, implemented pin.
        assign hit = wr_en && (waddr == WADDR_W'(WORD)) && be[LANE] && pin_impl[p];
        // Pin output register: reset low, loads lane bit 0 on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n)   pin_out[p] <= 1'b0;
            else if (hit) pin_out[p] <= wdata[LANE*LANE_W];
        end
    end
endmodule

// File: rtl/gpio_ba_readmux.sv
// Module gpio_ba_readmux
// Selects the four pins of the addressed word and formats each one as a
// 0x00 or 0x01 byte. The result is registered on a read access and held
// between reads. Assumes pin_in has already been synchronised.
module gpio_ba_readmux
    import gpio_ba_pkg::*;
#(
    parameter int unsigned NPINS   = 256,
    parameter int unsigned WADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [NPINS-1:0]   pin_in,
    input  logic [NPINS-1:0]   pin_ie,
    input  logic [NPINS-1:0]   pin_impl,
    output logic [BUS_W-1:0]   rdata
);
    logic [BUS_W-1:0] rdata_nxt;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [WADDR_W+LANE_AW-1:0] idx;
        assign idx = {waddr, LANE_AW'(k)};
        // Lane byte: level in bit 0 when enabled and implemented, upper bits zero.
        assign rdata_nxt[k*LANE_W +: LANE_W] =
            {{(LANE_W-1){1'b0}}, pin_in[idx] & pin_ie[idx] & pin_impl[idx]};
    end

    // Read data register: cleared by reset, loaded on each read access.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_en)  rdata <= rdata_nxt;
    end
endmodule

// File: rtl/gpio_byte_access.sv
// Module gpio_byte_access
// Bus front end that gives each GPIO pin its own byte address: pin m of
// port n is at byte address n*PORT_W+m. Assumes PORT_W is a multiple of 4
// and a bus that carries a word address with one strobe per byte.
module gpio_byte_access
    import gpio_ba_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8,
    parameter int unsigned PORT_W    = 32,
    parameter int unsigned CNT_W     = 6,
    parameter logic [NUM_PORTS*CNT_W-1:0] PORT_PINS =
        {6'd4, 6'd32, 6'd32, 6'd8, 6'd32, 6'd16, 6'd32, 6'd32},
    localparam int unsigned NPINS   = NUM_PORTS * PORT_W,
    localparam int unsigned ADDR_W  = $clog2(NPINS),
    localparam int unsigned WADDR_W = ADDR_W - LANE_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [WADDR_W-1:0] bus_waddr,
    input  logic [LANES-1:0]   bus_be,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    input  logic [NPINS-1:0]   pin_ie,
    output logic [NPINS-1:0]   pin_out
);
    logic [NPINS-1:0] pin_impl;
    logic             wr_en;
    logic             rd_en;

    // Access qualifiers for the two directions.
    assign wr_en = bus_sel &  bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    gpio_ba_decode #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .CNT_W     (CNT_W),
        .PORT_PINS (PORT_PINS)
    ) u_decode (
        .pin_impl (pin_impl)
    );

    gpio_ba_outreg #(
        .NPINS   (NPINS),
        .WADDR_W (WADDR_W)
    ) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .waddr    (bus_waddr),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .pin_impl (pin_impl),
        .pin_out  (pin_out)
    );

    gpio_ba_readmux #(
        .NPINS   (NPINS),
        .WADDR_W (WADDR_W)
    ) u_readmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .waddr    (bus_waddr),
        .pin_in   (pin_in),
        .pin_ie   (pin_ie),
        .pin_impl (pin_impl),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/gpio_ba_checker.sv
// Module gpio_ba_checker
// Property checks for gpio_byte_access, attached to it by bind. Derives
// its own map of reserved pins from the per-port counts.
module gpio_ba_checker
    import gpio_ba_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8,
    parameter int unsigned PORT_W    = 32,
    parameter int unsigned CNT_W     = 6,
    parameter logic [NUM_PORTS*CNT_W-1:0] PORT_PINS = '1,
    localparam int unsigned NPINS   = NUM_PORTS * PORT_W,
    localparam int unsigned ADDR_W  = $clog2(NPINS),
    localparam int unsigned WADDR_W = ADDR_W - LANE_AW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [WADDR_W-1:0] bus_waddr,
    input logic [LANES-1:0]   bus_be,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic [NPINS-1:0]   pin_in,
    input logic [NPINS-1:0]   pin_ie,
    input logic [NPINS-1:0]   pin_out
);
    logic [NPINS-1:0] exists;
    for (genvar p = 0; p < NPINS; p++) begin : g_exists
        assign exists[p] = ((p % PORT_W) < int'(PORT_PINS[(p / PORT_W)*CNT_W +: CNT_W]));
    end

    logic [ADDR_W-1:0] lane0_pin;
    assign lane0_pin = {bus_waddr, {LANE_AW{1'b0}}};

    AST_RESERVED_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~exists) == '0);                                            // R7
    AST_WRITE_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be[0] && exists[lane0_pin])
        |=> pin_out[$past(lane0_pin)] == $past(bus_wdata[0]));                 // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(pin_out));                            // R8
    AST_LANE_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & 32'hFEFE_FEFE) == '0);                                    // R5
    AST_READ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && exists[lane0_pin] && pin_ie[lane0_pin] && pin_in[lane0_pin])
        |=> bus_rdata[0]);                                                     // R5
    AST_IE_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !pin_ie[lane0_pin]) |=> !bus_rdata[0]);         // R6
    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !exists[lane0_pin]) |=> !bus_rdata[0]);         // R7
    AST_STROBE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_be[0]) |=> $stable(pin_out[$past(lane0_pin)])); // R4
endmodule

bind gpio_byte_access gpio_ba_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .CNT_W     (CNT_W),
    .PORT_PINS (PORT_PINS)
) u_gpio_ba_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_waddr (bus_waddr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_ie    (pin_ie),
    .pin_out   (pin_out)
);

// File: tb/test_gpio_byte_access.sv
// Scoreboard bench for gpio_byte_access: the driver tasks queue expected
// results, and a monitor compares them one cycle after the access.
module test_gpio_byte_access;
    localparam int NPINS = 256;
    localparam logic [47:0] COUNTS =
        {6'd4, 6'd32, 6'd32, 6'd8, 6'd32, 6'd16, 6'd32, 6'd32};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0;
    logic             bus_wr = 1'b0;
    logic [5:0]       bus_waddr = '0;
    logic [3:0]       bus_be = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pin_ie = '0;
    logic [NPINS-1:0] pin_out;

    gpio_byte_access #(.PORT_PINS(COUNTS)) i_gpio_byte_access (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_waddr(bus_waddr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_ie(pin_ie), .pin_out(pin_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        bit               is_rd;
        logic [NPINS-1:0] vec;
        string            req;
        int               due;
    } item_t;

    item_t            sb[$];
    int               checks = 0;
    int               failures = 0;
    int               cyc = 0;
    logic [NPINS-1:0] model_out = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit pin_exists(int p);
        return (p % 32) < int'(COUNTS[(p / 32)*6 +: 6]);
    endfunction

    task automatic check_val(string req, logic [NPINS-1:0] act, logic [NPINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop every due item and compare it with the design output.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.is_rd) check_val(it.req, NPINS'(bus_rdata), it.vec);
            else          check_val(it.req, pin_out, it.vec);
        end
    end

    task automatic bus_write(int byte_addr, logic [3:0] be, logic [31:0] wd, string req);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = 6'(byte_addr / 4);
        bus_be = be; bus_wdata = wd;
        for (int k = 0; k < 4; k++) begin
            int p;
            p = (byte_addr / 4) * 4 + k;
            if (be[k] && pin_exists(p)) model_out[p] = wd[8*k];
        end
        it.is_rd = 1'b0; it.vec = model_out; it.req = req; it.due = cyc + 1;
        sb.push_back(it);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(int byte_addr, string req);
        item_t it;
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = 6'(byte_addr / 4);
        bus_be = 4'hF; bus_wdata = 32'h0101_0101;
        e = '0;
        for (int k = 0; k < 4; k++) begin
            int p;
            p = (byte_addr / 4) * 4 + k;
            e[8*k] = pin_in[p] & pin_ie[p] & pin_exists(p);
        end
        it.is_rd = 1'b1; it.vec = NPINS'(e); it.req = req; it.due = cyc + 1;
        sb.push_back(it);
        it.is_rd = 1'b0; it.vec = model_out; it.req = "R8 read leaves outputs"; it.due = cyc + 1;
        sb.push_back(it);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_val("R1 pin_out in reset", pin_out, '0);
        check_val("R1 rdata in reset", NPINS'(bus_rdata), '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 pin_out after reset", pin_out, '0);

        bus_write(5, 4'b0010, 32'h0000_0100, "R2 byte port0 pin5");
        bus_write(127, 4'b1000, 32'h0100_0000, "R2 byte port3 pin31");
        bus_write(127, 4'b1000, 32'hFE00_0000, "R3 upper bits ignored");
        bus_write(72, 4'b0011, 32'h0000_0101, "R4 halfword port2 pins8-9");
        bus_write(32, 4'b1111, 32'h0100_0101, "R4 word port1 pins0-3");
        bus_write(32, 4'b0100, 32'h0101_0101, "R4 single strobe in word");
        bus_write(84, 4'b1111, 32'h0101_0101, "R7 reserved port2 pins20-23");
        bus_write(224, 4'b1111, 32'h0101_0101, "R2 last implemented port7 pins");
        bus_write(228, 4'b1111, 32'h0101_0101, "R7 reserved port7 pins4-7");
        bus_write(136, 4'b0001, 32'h0000_0001, "R7 reserved port4 pin8");
        repeat (3) begin
            item_t it;
            @(negedge clk);
            it.is_rd = 1'b0; it.vec = model_out; it.req = "R8 idle hold"; it.due = cyc + 1;
            sb.push_back(it);
        end

        @(negedge clk);
        pin_in = '1; pin_ie = '1;
        bus_read(76, "R5 read high port2 pins12-15");
        bus_read(84, "R7 read reserved port2");
        bus_read(228, "R7 read reserved port7");
        @(negedge clk);
        pin_ie[77] = 1'b0;
        bus_read(76, "R6 input disabled lane1");
        @(negedge clk);
        pin_in[3:0] = 4'b0101;
        bus_read(0, "R5 mixed levels port0");
        @(negedge clk);
        pin_ie = '0;
        bus_read(32, "R6 all inputs disabled");

        repeat (3) @(negedge clk);
        check_val("R5 scoreboard drained", NPINS'(sb.size()), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule